// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

This block gathers eight peripheral interrupt lines and presents one request line to a processor. A rising edge on a line records a pending request. Each line can be blocked through a mask register whose set bits disable the line. When an unblocked pending request outranks everything currently in service, the controller raises its request output. The processor answers with an acknowledge pulse. The controller then moves the winning request into service and presents a vector number equal to a programmable base plus the line index.

Requests that rank at or below the highest in-service entry wait, while a strictly higher request may nest on top of it. Software retires one in-service entry per end-of-interrupt command. Two priority schemes are offered. In fixed priority, line 0 is highest and line 7 lowest. In rotating priority, the line whose service was most recently completed drops to the lowest rank.

Software reaches four registers through a small write port selected by a 2-bit address. The mask value can always be read back on a dedicated data output.

Top module: `irqc_top`

## Requirements
- R1: After reset, int_req is 0, vec_out is 0, the mask reads 8'hFF (all lines disabled), the base is 0, and fixed priority is selected.
- R2: A write to address 0 loads the mask, and reg_rdata shows it from the next cycle. A mask bit of 1 disables its line and 0 enables it, so a pending request on a masked line never raises int_req.
- R3: A rising edge on irq_in[i] makes line i pending after the next clock edge. A line held high does not re-arm after it has been acknowledged. A pending bit clears only when that line is acknowledged.
- R4: In fixed priority mode (address 3, bit 0 = 0), the lowest-numbered eligible line wins.
- R5: On a cycle with int_ack and int_req both 1, vec_out becomes base (address 2) plus the winning index from the next cycle. vec_out holds its value at all other times.
- R6: int_req is 1 only when an unmasked pending line ranks strictly above every in-service line. Acknowledging it sets that line in service and clears its pending bit.
- R7: Writing data 8'h20 to address 1 is end of interrupt. It clears only the highest-ranked in-service entry. Any other data written to address 1 has no effect.
- R8: With address 3, bit 0 = 1 (rotating mode), the line retired by an end-of-interrupt becomes the lowest rank, and the next line above it becomes the highest. Rotation starts with line 7 lowest.
- R9: A request that arrives while its line is masked stays pending, and it raises int_req once the line is unmasked.
- R10: An int_ack while int_req is 0 changes neither the in-service state nor vec_out.

Register map: address 0 is the mask, address 1 the command, address 2 the vector base, and address 3 the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Peripheral request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Mask read-back |
| int_req | output | 1 | Request to the processor |
| int_ack | input | 1 | Acknowledge from the processor |
| vec_out | output | 8 | Vector of the last acknowledged request |

## Verification
Each result has a fixed due cycle:
- A rising edge on a line shows on int_req one clock edge later, because there is one pending register in the path.
- An acknowledge produces the new vec_out after the edge that takes it.
- A mask write or an end-of-interrupt changes int_req right after the edge that performs the write.

The bench drives inputs 1 ns after a rising edge and holds them through exactly one edge. It samples 1 ns after that edge, so every comparison falls in the first cycle where the result is due.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        ADDR_MASK = 2'd0,
        ADDR_CMD  = 2'd1,
        ADDR_BASE = 2'd2,
        ADDR_MODE = 2'd3
    } reg_addr_e;

    typedef enum logic {
        PRIO_FIXED  = 1'b0,
        PRIO_ROTATE = 1'b1
    } prio_mode_e;

    localparam logic [7:0] CMD_EOI = 8'h20;
endpackage

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int N_IN  = 8,
    parameter int IDX_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  req,
    input  logic [IDX_W-1:0] low,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] rank
);
    // Rank 0 is the line just after "low"; scan from lowest rank upward so
    // the last assignment is the best-ranked line.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        rank = '0;
        for (int k = N_IN - 1; k >= 0; k--) begin
            int line;
            line = (int'(low) + 1 + k) % N_IN;
            if (req[line]) begin
                hit  = 1'b1;
                idx  = IDX_W'(line);
                rank = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] irq_in,
    input  logic [N_IN-1:0] take,
    output logic [N_IN-1:0] pend
);
    logic [N_IN-1:0] irq_q;
    logic [N_IN-1:0] rise;

    assign rise = irq_in & ~irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            pend  <= '0;
        end else begin
            irq_q <= irq_in;
            pend  <= (pend & ~take) | rise;
        end
    end

    // R3: a pending bit only drops when that line is taken
    a_r3_pend_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend) & ~pend & ~$past(take)) == '0));
endmodule

// File: rtl/irqc_inservice.sv
module irqc_inservice #(
    parameter int N_IN  = 8,
    parameter int IDX_W = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N_IN-1:0]  isr
);
    logic [N_IN-1:0] set_vec;
    logic [N_IN-1:0] clr_vec;

    assign set_vec = set_en ? (N_IN'(1) << set_idx) : '0;
    assign clr_vec = clr_en ? (N_IN'(1) << clr_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) isr <= '0;
        else     isr <= (isr & ~clr_vec) | set_vec;
    end

    // R6: an accepted acknowledge adds exactly one in-service entry
    a_r6_ack_adds_one: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en) |=> ($countones(isr) == $countones($past(isr)) + 1));

    // R7: end of interrupt retires exactly one in-service entry
    a_r7_eoi_drops_one: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> ($countones(isr) + 1 == $countones($past(isr))));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  irq_in,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [VEC_W-1:0] reg_wdata,
    output logic [N_IN-1:0]  reg_rdata,
    output logic             int_req,
    input  logic             int_ack,
    output logic [VEC_W-1:0] vec_out
);
    localparam int IDX_W = $clog2(N_IN);
    localparam logic [IDX_W-1:0] LOW_RESET = IDX_W'(N_IN - 1);

    logic [N_IN-1:0]  mask_q;
    logic [VEC_W-1:0] base_q;
    prio_mode_e       mode_q;
    logic [IDX_W-1:0] low_q;
    logic [IDX_W-1:0] low_eff;

    logic [N_IN-1:0]  pend;
    logic [N_IN-1:0]  isr;
    logic [N_IN-1:0]  take;
    logic             win_hit, top_hit;
    logic [IDX_W-1:0] win_idx, win_rank, top_idx, top_rank;
    logic             accept, eoi, retire;

    assign low_eff = (mode_q == PRIO_ROTATE) ? low_q : LOW_RESET;

    irqc_pending #(.N_IN(N_IN)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .take   (take),
        .pend   (pend)
    );

    irqc_pick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_pick_req (
        .req  (pend & ~mask_q),
        .low  (low_eff),
        .hit  (win_hit),
        .idx  (win_idx),
        .rank (win_rank)
    );

    irqc_pick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_pick_isr (
        .req  (isr),
        .low  (low_eff),
        .hit  (top_hit),
        .idx  (top_idx),
        .rank (top_rank)
    );

    assign int_req = win_hit && (!top_hit || (win_rank < top_rank));
    assign accept  = int_req && int_ack;
    assign eoi     = reg_wr && (reg_addr == ADDR_CMD) && (reg_wdata == VEC_W'(CMD_EOI));
    assign retire  = eoi && top_hit;
    assign take    = accept ? (N_IN'(1) << win_idx) : '0;

    irqc_inservice #(.N_IN(N_IN), .IDX_W(IDX_W)) u_isr (
        .clk     (clk),
        .rst     (rst),
        .set_en  (accept),
        .set_idx (win_idx),
        .clr_en  (retire),
        .clr_idx (top_idx),
        .isr     (isr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            base_q  <= '0;
            mode_q  <= PRIO_FIXED;
            low_q   <= LOW_RESET;
            vec_out <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    ADDR_MASK: mask_q <= reg_wdata[N_IN-1:0];
                    ADDR_BASE: base_q <= reg_wdata;
                    ADDR_MODE: mode_q <= prio_mode_e'(reg_wdata[0]);
                    default:   ;
                endcase
            end
            if (retire && (mode_q == PRIO_ROTATE)) low_q <= top_idx;
            if (accept) vec_out <= base_q + VEC_W'(win_idx);
        end
    end

    assign reg_rdata = mask_q;

    // R5: vector only moves on an accepted acknowledge
    a_r5_vec_hold: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(vec_out));

    // R10: a stray acknowledge leaves in-service state untouched
    a_r10_stray_ack: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_req && !eoi) |=> $stable(isr));

    // R2: a request output always has an unmasked pending line behind it
    a_r2_req_unmasked: assert property (@(posedge clk) disable iff (rst)
        int_req |-> ((pend & ~mask_q) != '0));
endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       int_req;
    logic       int_ack;
    logic [7:0] vec_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    irqc_top u0 (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .int_req   (int_req),
        .int_ack   (int_ack),
        .vec_out   (vec_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic ack();
        int_ack = 1'b1;
        step();
        int_ack = 1'b0;
    endtask

    task automatic raise(input int i);
        irq_in[i] = 1'b1;
        step();
    endtask

    task automatic drop_all();
        irq_in = '0;
        step();
    endtask

    task automatic t_reset();
        chk("R1 int_req", {7'd0, int_req}, 8'h00);
        chk("R1 vec_out", vec_out, 8'h00);
        chk("R1 mask", reg_rdata, 8'hFF);
    endtask

    task automatic t_mask();
        wr(2'd0, 8'hF0);
        chk("R2 mask readback", reg_rdata, 8'hF0);
        raise(5);
        chk("R2 masked line no req", {7'd0, int_req}, 8'h00);
        wr(2'd0, 8'h00);
        chk("R9 unmask raises req", {7'd0, int_req}, 8'h01);
        ack();
        chk("R5 vec base0+5", vec_out, 8'h05);
        chk("R6 req drops after ack", {7'd0, int_req}, 8'h00);
        wr(2'd1, 8'h20);
        drop_all();
    endtask

    task automatic t_edge();
        wr(2'd2, 8'h08);
        raise(3);
        chk("R3 edge pends", {7'd0, int_req}, 8'h01);
        ack();
        chk("R5 vec 08+3", vec_out, 8'h0B);
        wr(2'd1, 8'h20);
        step();
        chk("R3 held level no rearm", {7'd0, int_req}, 8'h00);
        drop_all();
    endtask

    task automatic t_fixed();
        irq_in[6] = 1'b1; irq_in[2] = 1'b1;
        step();
        ack();
        chk("R4 lower index wins", vec_out, 8'h0A);
        chk("R6 lower waits on isr", {7'd0, int_req}, 8'h00);
        wr(2'd1, 8'h20);
        chk("R7 eoi releases waiter", {7'd0, int_req}, 8'h01);
        ack();
        chk("R4 second winner", vec_out, 8'h0E);
        wr(2'd1, 8'h20);
        drop_all();
    endtask

    task automatic t_nest();
        raise(4);
        ack();
        chk("R5 vec line4", vec_out, 8'h0C);
        raise(1);
        chk("R6 higher preempts", {7'd0, int_req}, 8'h01);
        ack();
        chk("R6 nested vec", vec_out, 8'h09);
        raise(7);
        chk("R6 lower blocked", {7'd0, int_req}, 8'h00);
        wr(2'd1, 8'h21);
        raise(2);
        chk("R7 non-eoi ignored", {7'd0, int_req}, 8'h00);
        wr(2'd1, 8'h20);
        chk("R7 eoi clears top only", {7'd0, int_req}, 8'h01);
        ack();
        chk("R7 line2 served", vec_out, 8'h0A);
        wr(2'd1, 8'h20);
        chk("R7 line4 still in service", {7'd0, int_req}, 8'h00);
        wr(2'd1, 8'h20);
        chk("R7 line7 released", {7'd0, int_req}, 8'h01);
        ack();
        chk("R5 vec line7", vec_out, 8'h0F);
        wr(2'd1, 8'h20);
        drop_all();
    endtask

    task automatic t_stray_ack();
        ack();
        chk("R10 vec unchanged", vec_out, 8'h0F);
        chk("R10 no req", {7'd0, int_req}, 8'h00);
        raise(6);
        ack();
        chk("R10 isr untouched, line6 served", vec_out, 8'h0E);
        wr(2'd1, 8'h20);
        drop_all();
    endtask

    task automatic t_rotate();
        wr(2'd3, 8'h01);
        irq_in[0] = 1'b1; irq_in[5] = 1'b1;
        step();
        ack();
        chk("R8 start: line0 highest", vec_out, 8'h08);
        chk("R8 line5 waits", {7'd0, int_req}, 8'h00);
        wr(2'd1, 8'h20);
        irq_in[0] = 1'b0;
        step();
        raise(0);
        ack();
        chk("R8 line0 now lowest", vec_out, 8'h0D);
        chk("R8 line0 below line5", {7'd0, int_req}, 8'h00);
        wr(2'd1, 8'h20);
        chk("R8 release after eoi", {7'd0, int_req}, 8'h01);
        ack();
        chk("R8 line0 served", vec_out, 8'h08);
        wr(2'd1, 8'h20);
        drop_all();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_in = '0; reg_wr = 1'b0; reg_addr = '0;
        reg_wdata = '0; int_ack = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        step();
        t_reset();
        t_mask();
        t_edge();
        t_fixed();
        t_nest();
        t_stray_ack();
        t_rotate();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule